// File: doc/BRIEF.md
# Tagged SMBus Target Receive Unit

This block is the register-facing half of the target side of a two-wire serial bus controller. A bus-side engine, which handles the pins, START/STOP detection and acknowledge driving, hands it byte-level events. Each event is one of three kinds: an address byte with its direction bit, a data byte, or a stop. The unit decides whether the address belongs to this target by checking it against four programmable slots. For host writes, it queues every byte in a 64-entry receive FIFO. Each entry is tagged so software can tell where a transaction starts and ends.

For host reads, software preloads a small transmit FIFO, which the engine drains byte by byte. A command/status word reports whether a transaction is in flight and how it ended. A clock-stretch watchdog aborts a transaction when the target holds the clock too long. Interrupt status bits are sticky, and an enable mask turns them into a single interrupt line.

Software sees eight word registers through a simple single-cycle port:
- offset 0: address configuration
- offset 1: timing
- offset 2: FIFO control
- offset 3: command
- offset 4: interrupt enable
- offset 5: interrupt status
- offset 6: transmit data
- offset 7: receive data

Event kinds on `evtKind` are 0 = address, 1 = data, 2 = stop.

Top module: `smbt_top`

## Requirements
- R1: The configuration word (offset 0) holds four 7-bit slots at bits 6:0, 14:8, 22:16, 30:24, each enabled by bit 7, 15, 23, 31. An address event whose byte bits 7:1 equal an enabled slot raises `addrHit` in the same cycle. Disabled or unequal slots never hit.
- R2: A receive-data read (offset 7) returns tag bits 31:30, the PEC error flag in bit 29 and the data in bits 7:0, then pops the entry. The tag is 1 for the first data byte of a matched host write, 2 for each later byte, and 3 for the entry that a stop pushes (data 0). An empty FIFO reads as all zeros (tag 0).
- R3: The receive FIFO holds 64 entries. A push into a full FIFO is dropped, stored entries stay intact, and status bit 26 is set.
- R4: A single transaction stores at most 64 data bytes. Later data bytes in the same transaction are dropped without setting any status.
- R5: FIFO control reads (offset 2) report the receive count in bits 22:16 and the threshold in bits 13:8. Status bit 24 is set while the receive FIFO is not empty. Status bit 25 is set while a nonzero threshold is met or exceeded.
- R6: An address match with direction bit 1 sets status bit 21 and the busy bit (offset 3, bit 31), and stores nothing in the receive FIFO. Bytes written to offset 6 come out on `txData` in order as the engine pulses `txPop`.
- R7: Status bit 22 is set when a `txPop` during a read transaction leaves the transmit FIFO empty.
- R8: A stop during a matched transaction clears busy, sets the 3-bit status (offset 3, bits 25:23) to 0, and sets status bit 23.
- R9: While `stretchActive` is high in a transaction, each `stretchTick` advances a counter; the counter restarts when `stretchActive` drops. A tick that takes the count above the limit (offset 1, bits 30:24) pulses `busAbort`, ends the transaction, clears busy, sets status 5 and sets bit 23.
- R10: Interrupt status (offset 5) is write-one-to-clear. `irq` is high exactly when some status bit and its enable bit (offset 4) are both set.
- R11: Writing FIFO control with bit 31 set empties the receive FIFO; with bit 30 set it empties the transmit FIFO.
- R12: The status field of the command word reads as 0 while busy is set, even if the last transaction timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Bus event present this cycle |
| evtKind | input | 2 | 0 address, 1 data, 2 stop |
| evtByte | input | 8 | Address byte (7:1 address, 0 direction) or data byte |
| evtPecErr | input | 1 | PEC error flag for the byte |
| addrHit | output | 1 | Address event matches an enabled slot |
| txPop | input | 1 | Engine takes one transmit byte |
| txData | output | 8 | Head of the transmit FIFO |
| txEmpty | output | 1 | Transmit FIFO is empty |
| stretchActive | input | 1 | Engine is stretching the clock |
| stretchTick | input | 1 | Prescaled tick for the stretch counter |
| busAbort | output | 1 | Stretch timeout abort pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on offset 7) |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the collision between the per-transaction byte limit and a full receive FIFO. The stimulus sends 66 data bytes in one transaction: the last two are dropped silently under the transaction limit, and then the stop's end entry finds the FIFO full and sets the overflow flag. The stretch watchdog is driven tick by tick so that the abort lands exactly one tick past the limit. A second run drops `stretchActive` midway to show that the count restarts. A sweep over all 128 addresses, with two slots enabled and two disabled, covers the matcher.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [1:0] {EVT_ADDR = 2'd0, EVT_DATA = 2'd1, EVT_STOP = 2'd2} evtKind_e;
  typedef enum logic [1:0] {TAG_EMPTY = 2'd0, TAG_START = 2'd1, TAG_DATA = 2'd2, TAG_END = 2'd3} rxTag_e;

  typedef struct packed {
    logic [1:0] tag;
    logic       pec;
    logic [7:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic       rxPush;
    rxEntry_t   rxIn;
    logic       rxPop;
    logic       rxFlush;
    logic       txPush;
    logic [7:0] txIn;
    logic       txPop;
    logic       txFlush;
  } dpStrobe_t;

  localparam logic [2:0] REG_ADDRCFG = 3'd0;
  localparam logic [2:0] REG_TIMING  = 3'd1;
  localparam logic [2:0] REG_FIFOCTL = 3'd2;
  localparam logic [2:0] REG_CMD     = 3'd3;
  localparam logic [2:0] REG_IE      = 3'd4;
  localparam logic [2:0] REG_IS      = 3'd5;
  localparam logic [2:0] REG_TXDATA  = 3'd6;
  localparam logic [2:0] REG_RXDATA  = 3'd7;

  localparam int IS_RXFULL = 26;
  localparam int IS_THLD   = 25;
  localparam int IS_RXEVT  = 24;
  localparam int IS_DONE   = 23;
  localparam int IS_UNDER  = 22;
  localparam int IS_RDREQ  = 21;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_TIMEOUT = 3'd5;
endpackage

// File: rtl/smbt_fifo.sv
module smbt_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != FULL);
  assign doPop  = pop && (count != '0);
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= din;
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL && push && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/smbt_datapath.sv
module smbt_datapath import smbt_pkg::*; #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 4,
  localparam int RCW = $clog2(RX_DEPTH) + 1,
  localparam int TCW = $clog2(TX_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strb,
  output rxEntry_t       rxHead,
  output logic [RCW-1:0] rxCount,
  output logic [7:0]     txHead,
  output logic [TCW-1:0] txCount
);
  localparam int EW = $bits(rxEntry_t);
  logic [EW-1:0] rxRaw;

  smbt_fifo #(.DEPTH(RX_DEPTH), .WIDTH(EW)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(strb.rxPush), .din(strb.rxIn),
    .pop(strb.rxPop), .flush(strb.rxFlush), .dout(rxRaw), .count(rxCount));

  smbt_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(strb.txPush), .din(strb.txIn),
    .pop(strb.txPop), .flush(strb.txFlush), .dout(txHead), .count(txCount));

  assign rxHead = rxEntry_t'(rxRaw);
endmodule

// File: rtl/smbt_ctrl.sv
module smbt_ctrl import smbt_pkg::*; #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 4,
  parameter int MAX_XFER = 64,
  parameter int SLOTS    = 4,
  localparam int RCW = $clog2(RX_DEPTH) + 1,
  localparam int TCW = $clog2(TX_DEPTH) + 1,
  localparam int XW  = $clog2(MAX_XFER) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           evtValid,
  input  logic [1:0]     evtKind,
  input  logic [7:0]     evtByte,
  input  logic           evtPecErr,
  output logic           addrHit,
  input  logic           txPop,
  input  logic           stretchActive,
  input  logic           stretchTick,
  output logic           busAbort,
  input  logic           regWrEn,
  input  logic           regRdEn,
  input  logic [2:0]     regAddr,
  input  logic [31:0]    regWrData,
  output logic [31:0]    regRdData,
  output logic           irq,
  input  rxEntry_t       rxHead,
  input  logic [RCW-1:0] rxCount,
  input  logic [TCW-1:0] txCount,
  output dpStrobe_t      strb
);
  localparam logic [XW-1:0]  XMAX   = XW'(MAX_XFER);
  localparam logic [RCW-1:0] RXFULL = RCW'(RX_DEPTH);

  logic [31:0] addrCfg, ieReg, isReg, setBits;
  logic [6:0]  stretchLim;
  logic [5:0]  thld;
  logic [2:0]  status;
  logic [7:0]  stretchCnt;
  logic [XW-1:0] xferCnt;
  logic busy, active, isRead, first;
  logic slotMatch, dataEvt, stopEvt, wantData, wantEnd, rxOvf, underrun, timeoutHit, stopEnd;
  evtKind_e kind;

  assign kind = evtKind_e'(evtKind);

  always_comb begin
    slotMatch = 1'b0;
    for (int s = 0; s < SLOTS; s++)
      if (addrCfg[8*s+7] && addrCfg[8*s +: 7] == evtByte[7:1]) slotMatch = 1'b1;
  end

  assign addrHit    = evtValid && kind == EVT_ADDR && slotMatch;
  assign dataEvt    = evtValid && kind == EVT_DATA;
  assign stopEvt    = evtValid && kind == EVT_STOP;
  assign stopEnd    = stopEvt && active;
  assign wantData   = dataEvt && active && !isRead && xferCnt < XMAX;
  assign wantEnd    = stopEnd && !isRead;
  assign rxOvf      = (wantData || wantEnd) && rxCount == RXFULL;
  assign underrun   = txPop && active && isRead && txCount <= TCW'(1);
  assign timeoutHit = active && stretchActive && stretchTick && (stretchCnt + 8'd1 > {1'b0, stretchLim});
  assign busAbort   = timeoutHit;
  assign irq        = |(isReg & ieReg);

  always_comb begin
    strb = '0;
    strb.rxPush    = (wantData || wantEnd) && rxCount != RXFULL;
    strb.rxIn.tag  = wantEnd ? TAG_END : (first ? TAG_START : TAG_DATA);
    strb.rxIn.pec  = evtPecErr;
    strb.rxIn.data = wantEnd ? 8'h00 : evtByte;
    strb.rxPop     = regRdEn && regAddr == REG_RXDATA && rxCount != '0;
    strb.rxFlush   = regWrEn && regAddr == REG_FIFOCTL && regWrData[31];
    strb.txFlush   = regWrEn && regAddr == REG_FIFOCTL && regWrData[30];
    strb.txPush    = regWrEn && regAddr == REG_TXDATA;
    strb.txIn      = regWrData[7:0];
    strb.txPop     = txPop && txCount != '0;
  end

  always_comb begin
    setBits = '0;
    setBits[IS_RXFULL] = rxOvf;
    setBits[IS_THLD]   = thld != '0 && rxCount >= RCW'(thld);
    setBits[IS_RXEVT]  = rxCount != '0;
    setBits[IS_DONE]   = stopEnd || timeoutHit;
    setBits[IS_UNDER]  = underrun;
    setBits[IS_RDREQ]  = addrHit && evtByte[0];
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_ADDRCFG: regRdData = addrCfg;
      REG_TIMING:  regRdData[30:24] = stretchLim;
      REG_FIFOCTL: begin regRdData[16 +: RCW] = rxCount; regRdData[13:8] = thld; end
      REG_CMD:     begin regRdData[31] = busy; regRdData[25:23] = busy ? 3'd0 : status; end
      REG_IE:      regRdData = ieReg;
      REG_IS:      regRdData = isReg;
      REG_TXDATA:  regRdData = '0;
      REG_RXDATA:  if (rxCount != '0) regRdData = {rxHead.tag, rxHead.pec, 21'd0, rxHead.data};
      default:     regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrCfg <= '0; ieReg <= '0; isReg <= '0; stretchLim <= '0; thld <= '0;
      status <= ST_OK; busy <= 1'b0; active <= 1'b0; isRead <= 1'b0; first <= 1'b0;
      xferCnt <= '0; stretchCnt <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          REG_ADDRCFG: addrCfg <= regWrData;
          REG_TIMING:  stretchLim <= regWrData[30:24];
          REG_FIFOCTL: thld <= regWrData[13:8];
          REG_CMD:     if (regWrData[31]) busy <= 1'b1;
          REG_IE:      ieReg <= regWrData;
          default: ;
        endcase
      end
      isReg <= (isReg & ~((regWrEn && regAddr == REG_IS) ? regWrData : 32'd0)) | setBits;

      if (addrHit) begin
        active <= 1'b1; isRead <= evtByte[0]; busy <= 1'b1; first <= 1'b1; xferCnt <= '0;
      end
      if (wantData) begin
        xferCnt <= xferCnt + 1'b1;
        first   <= 1'b0;
      end
      if (stopEnd) begin
        active <= 1'b0; busy <= 1'b0; status <= ST_OK;
      end

      if (!stretchActive || !active) stretchCnt <= '0;
      else if (stretchTick)          stretchCnt <= stretchCnt + 8'd1;
      if (timeoutHit) begin
        active <= 1'b0; busy <= 1'b0; status <= ST_TIMEOUT; stretchCnt <= '0;
      end
    end
  end

  p_stop_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopEnd && !timeoutHit |=> (!busy && isReg[IS_DONE]));
  p_timeout_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutHit |=> (status == ST_TIMEOUT && !busy && !active));
  p_read_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addrHit && evtByte[0] && !timeoutHit) |=> (busy && isReg[IS_RDREQ]));
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> isReg[IS_DONE]);
endmodule

// File: rtl/smbt_top.sv
module smbt_top import smbt_pkg::*; #(
  parameter int RX_DEPTH = 64,
  parameter int TX_DEPTH = 4,
  parameter int MAX_XFER = 64,
  localparam int RCW = $clog2(RX_DEPTH) + 1,
  localparam int TCW = $clog2(TX_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [1:0]  evtKind,
  input  logic [7:0]  evtByte,
  input  logic        evtPecErr,
  output logic        addrHit,
  input  logic        txPop,
  output logic [7:0]  txData,
  output logic        txEmpty,
  input  logic        stretchActive,
  input  logic        stretchTick,
  output logic        busAbort,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq
);
  dpStrobe_t      strb;
  rxEntry_t       rxHead;
  logic [RCW-1:0] rxCount;
  logic [TCW-1:0] txCount;

  smbt_ctrl #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .MAX_XFER(MAX_XFER)) ctrl_i (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind), .evtByte(evtByte),
    .evtPecErr(evtPecErr), .addrHit(addrHit), .txPop(txPop), .stretchActive(stretchActive),
    .stretchTick(stretchTick), .busAbort(busAbort), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .rxHead(rxHead), .rxCount(rxCount), .txCount(txCount), .strb(strb));

  smbt_datapath #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxHead(rxHead), .rxCount(rxCount),
    .txHead(txData), .txCount(txCount));

  assign txEmpty = txCount == '0;
endmodule

// File: tb/smbt_top_tb_top.sv
module smbt_top_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic evtValid = 0, evtPecErr = 0, txPop = 0, stretchActive = 0, stretchTick = 0;
  logic regWrEn = 0, regRdEn = 0;
  logic [1:0] evtKind = 0;
  logic [7:0] evtByte = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0;
  logic addrHit, txEmpty, busAbort, irq;
  logic [7:0] txData;
  logic [31:0] regRdData;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smbt_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic evt(input logic [1:0] k, input logic [7:0] b, input logic p, output logic hit);
    @(negedge clk); evtValid = 1; evtKind = k; evtByte = b; evtPecErr = p; #1 hit = addrHit;
    @(negedge clk); evtValid = 0; evtPecErr = 0;
  endtask

  task automatic tick(output logic ab);
    @(negedge clk); stretchTick = 1; #1 ab = busAbort;
    @(negedge clk); stretchTick = 0;
  endtask

  task automatic cleanAll();
    logic [31:0] d;
    wr(3'd2, 32'hC000_0000); idle(2);
    wr(3'd5, 32'hFFFF_FFFF); idle(1);
    rd(3'd5, d);
    chk(d == 0, "R10 status cleared", d, 0);
  endtask

  initial begin
    logic [31:0] d;
    logic h, ab;
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(1);
    chk(irq == 0, "R10 reset irq", irq, 0);
    rd(3'd3, d); chk(d == 0, "R8 reset cmd", d, 0);
    rd(3'd2, d); chk(d == 0, "R5 reset count", d, 0);
    rd(3'd7, d); chk(d == 0, "R2 empty read", d, 0);

    // R1: slots 0x12 and 0x33 enabled, 0x55 and 0x7F disabled
    wr(3'd0, {1'b0, 7'h7F, 1'b1, 7'h33, 1'b0, 7'h55, 1'b1, 7'h12});
    for (int a = 0; a < 128; a++) begin
      evt(2'd0, {a[6:0], 1'b0}, 0, h);
      chk(h == (a == 'h12 || a == 'h33), "R1 address match", {31'd0, h}, {31'd0, (a == 'h12 || a == 'h33)});
    end
    evt(2'd2, 0, 0, h);
    cleanAll();

    // R2/R5/R8: write transactions of 0..5 bytes
    for (int n = 0; n < 6; n++) begin
      evt(2'd0, 8'h66, 0, h);
      for (int i = 0; i < n; i++) evt(2'd1, 8'(n * 16 + i), (n % 2 == 1) && (i == n - 1), h);
      evt(2'd2, 0, 0, h);
      idle(2);
      rd(3'd2, d); chk(d[22:16] == 7'(n + 1), "R5 count field", {25'd0, d[22:16]}, n + 1);
      rd(3'd5, d); chk(d[23] && d[24], "R8 done and R5 rx event", d, 32'h0180_0000);
      rd(3'd3, d); chk(d == 0, "R8 idle success", d, 0);
      for (int i = 0; i <= n; i++) begin
        logic [31:0] e;
        if (i == n) e = 32'hC000_0000;
        else e = ((i == 0 ? 32'd1 : 32'd2) << 30) | (32'((n % 2 == 1) && (i == n - 1)) << 29) | 32'(n * 16 + i);
        rd(3'd7, d); chk(d == e, "R2 tagged entry", d, e);
      end
      rd(3'd7, d); chk(d == 0, "R2 drained", d, 0);
      idle(1);
      cleanAll();
    end

    // R5/R10: threshold 3, enable rx event and threshold interrupts
    wr(3'd4, 32'h0300_0000);
    wr(3'd2, 32'h0000_0300);
    evt(2'd0, 8'h24, 0, h);
    evt(2'd1, 8'hA0, 0, h); evt(2'd1, 8'hA1, 0, h);
    idle(2);
    rd(3'd5, d); chk(d[25:24] == 2'b01, "R5 below threshold", d, 32'h0100_0000);
    chk(irq == 1, "R10 irq on rx event", irq, 1);
    evt(2'd1, 8'hA2, 0, h);
    idle(2);
    rd(3'd5, d); chk(d[25:24] == 2'b11, "R5 threshold met", d, 32'h0300_0000);
    evt(2'd2, 0, 0, h);
    wr(3'd2, 32'hC000_0000); idle(2);
    wr(3'd5, 32'h0100_0000); idle(1);
    rd(3'd5, d); chk(d == 32'h0280_0000, "R10 partial W1C", d, 32'h0280_0000);
    wr(3'd5, 32'hFFFF_FFFF); idle(1);
    chk(irq == 0, "R10 irq low", irq, 0);
    wr(3'd4, 0);

    // R9: limit 3, fourth tick aborts
    wr(3'd1, 32'h0300_0000);
    evt(2'd0, 8'h24, 0, h);
    @(negedge clk); stretchActive = 1;
    for (int t = 0; t < 3; t++) begin tick(ab); chk(ab == 0, "R9 no early abort", ab, 0); end
    tick(ab); chk(ab == 1, "R9 abort on limit+1", ab, 1);
    rd(3'd3, d); chk(d == 32'h0280_0000, "R9 timeout status", d, 32'h0280_0000);
    rd(3'd5, d); chk(d[23], "R9 done bit", d, 32'h0080_0000);
    @(negedge clk); stretchActive = 0;
    // R12: status hidden while busy
    evt(2'd0, 8'h24, 0, h);
    rd(3'd3, d); chk(d == 32'h8000_0000, "R12 status zero while busy", d, 32'h8000_0000);
    // R9: counter restarts when stretching stops
    @(negedge clk); stretchActive = 1;
    for (int t = 0; t < 3; t++) tick(ab);
    @(negedge clk); stretchActive = 0;
    @(negedge clk); stretchActive = 1;
    for (int t = 0; t < 3; t++) begin tick(ab); chk(ab == 0, "R9 restart no abort", ab, 0); end
    @(negedge clk); stretchActive = 0;
    rd(3'd3, d); chk(d[31], "R9 still busy", d, 32'h8000_0000);
    evt(2'd2, 0, 0, h);
    cleanAll();

    // R6/R7: read transaction
    wr(3'd6, 32'hA1); wr(3'd6, 32'hA2);
    evt(2'd0, 8'h67, 0, h);
    idle(1);
    rd(3'd5, d); chk(d[21] && !d[22], "R6 read request", d, 32'h0020_0000);
    rd(3'd3, d); chk(d[31], "R6 busy set", d, 32'h8000_0000);
    @(negedge clk); txPop = 1; #1 d = {24'd0, txData};
    @(negedge clk); txPop = 0;
    chk(d[7:0] == 8'hA1, "R6 tx byte order", d, 32'hA1);
    rd(3'd5, d); chk(!d[22], "R7 no underrun yet", d, 0);
    @(negedge clk); txPop = 1; #1 d = {24'd0, txData};
    @(negedge clk); txPop = 0;
    chk(d[7:0] == 8'hA2, "R6 tx byte order", d, 32'hA2);
    rd(3'd5, d); chk(d[22], "R7 underrun", d, 32'h0040_0000);
    chk(txEmpty == 1, "R7 tx empty", txEmpty, 1);
    evt(2'd2, 0, 0, h);
    idle(2);
    rd(3'd2, d); chk(d[22:16] == 0, "R6 read stores nothing", d, 0);
    cleanAll();

    // R3/R4: 66 bytes, last two dropped by limit, end entry hits full FIFO
    evt(2'd0, 8'h24, 0, h);
    for (int i = 0; i < 66; i++) evt(2'd1, 8'(i), 0, h);
    idle(2);
    rd(3'd2, d); chk(d[22:16] == 7'd64, "R4 capped at 64", d, 64);
    rd(3'd5, d); chk(!d[26], "R4 no overflow flag", d, 0);
    evt(2'd2, 0, 0, h);
    idle(1);
    rd(3'd5, d); chk(d[26], "R3 overflow flag", d, 32'h0400_0000);
    rd(3'd2, d); chk(d[22:16] == 7'd64, "R3 count held", d, 64);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] e;
      e = ((i == 0 ? 32'd1 : 32'd2) << 30) | 32'(i);
      rd(3'd7, d); chk(d == e, "R3 stored data intact", d, e);
    end
    rd(3'd7, d); chk(d == 0, "R3 no end entry", d, 0);
    idle(1);
    cleanAll();

    // R11: flushes
    evt(2'd0, 8'h24, 0, h); evt(2'd1, 8'h11, 0, h); evt(2'd2, 0, 0, h);
    idle(1);
    rd(3'd2, d); chk(d[22:16] == 7'd2, "R11 before flush", d, 2);
    wr(3'd2, 32'h8000_0000); idle(1);
    rd(3'd2, d); chk(d[22:16] == 0, "R11 rx flushed", d, 0);
    wr(3'd6, 32'h5A); idle(1);
    chk(txEmpty == 0, "R11 tx loaded", txEmpty, 0);
    wr(3'd2, 32'h4000_0000); idle(1);
    chk(txEmpty == 1, "R11 tx flushed", txEmpty, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule